// File: doc/BRIEF.md
# Tagged Translation Cache with Selective Invalidation

This block is a small, fully associative cache of address translations. Each slot holds a virtual page number, a physical frame number, a write permission bit, an address-space tag, a virtual-machine tag and a generation number.

The core presents a virtual address, an access kind (read or write) and its current context: address-space tag, VM tag and generation. One cycle later it gets back a hit flag, the physical address and a protection-fault flag. A context switch is only a change of the context inputs. Nothing is flushed, and slots that belong to other contexts simply stop matching.

After a miss, the page-table walker supplies the translation through the fill port, and the fill installs it under the current context. Through the invalidation port, stale translations can be dropped in three ways: every slot, every slot holding one virtual page, or every slot holding one address-space tag.

Top module: `xlate_cache`

## Requirements
- R1: A lookup hits only when a valid slot matches the virtual page (vaddr[31:12]), the current address-space tag, the current VM tag and the current generation. The result appears on the rsp_* outputs in the cycle after lk_valid is sampled. On a hit rsp_paddr = {pfn, vaddr[11:0]}. With no hit rsp_paddr is zero.
- R2: Changing ctx_asid invalidates nothing. Slots of other tags stay resident and hit again once their tag is current.
- R3: inv_op = 2'd1 (flush all) clears every slot, so no earlier translation hits afterwards.
- R4: inv_op = 2'd2 (flush page) clears every slot whose virtual page equals inv_vpn, whatever its tags, and leaves all other slots intact.
- R5: inv_op = 2'd3 (flush space) clears every slot whose address-space tag equals inv_asid, and leaves slots of other tags intact. inv_op = 2'd0 does nothing.
- R6: A valid slot whose stored generation differs from ctx_gen never hits.
- R7: A write lookup that matches a slot with fill_writable = 0 returns rsp_fault = 1, rsp_hit = 0 and rsp_paddr = 0. A read of the same slot hits normally.
- R8: A fill installs {fill_vpn, fill_pfn, fill_writable} under the current ctx_asid, ctx_vm and ctx_gen, so a repeat of that access hits. A fill whose page and tags equal those of a resident slot overwrites that slot, whatever the slot's generation, so at most one slot ever matches.
- R9: A new fill takes the lowest-numbered invalid slot. When all slots are valid, it takes the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one only on such an eviction.
- R10: When a fill and an invalidate arrive in the same cycle, the invalidate is applied first. The fill is dropped if its own page and tags meet the invalidation criteria, and installed otherwise.
- R11: After reset no slot is valid and rsp_valid, rsp_hit, rsp_fault and rsp_paddr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_asid | input | 8 | Current address-space tag |
| ctx_vm | input | 4 | Current virtual-machine tag |
| ctx_gen | input | 4 | Current generation for ctx_asid |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of lookup |
| lk_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_hit | output | 1 | Translation returned |
| rsp_fault | output | 1 | Write to read-only page |
| rsp_paddr | output | 32 | Physical address |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page to install |
| fill_pfn | input | 20 | Physical frame to install |
| fill_writable | input | 1 | Write permission of the translation |
| inv_valid | input | 1 | Invalidate request |
| inv_op | input | 2 | 0 none, 1 all, 2 page, 3 address space |
| inv_vpn | input | 20 | Page for the flush-page command |
| inv_asid | input | 8 | Tag for the flush-space command |

## Verification
The hardest behaviour to reach from the ports is the round-robin eviction. The replacement pointer only moves when every slot is already valid. The stimulus therefore flushes the array, fills all sixteen slots with distinct pages and adds two more fills. It then confirms at the lookup port that exactly the two oldest pages vanished.

A page invalidate then opens one hole to show that a free slot takes priority over the pointer. A fill and an invalidate are also driven in the same cycle, once with a fill that meets the invalidation criteria and once with one that does not.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int OFF_W = 12;
  localparam int AS_W  = 8;
  localparam int VM_W  = 4;
  localparam int GEN_W = 4;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  typedef enum logic [1:0] {
    INV_NONE  = 2'd0,
    INV_ALL   = 2'd1,
    INV_PAGE  = 2'd2,
    INV_SPACE = 2'd3
  } inv_op_e;

  typedef struct packed {
    logic             valid;
    logic             writable;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic [AS_W-1:0]  asid;
    logic [VM_W-1:0]  vm;
    logic [GEN_W-1:0] gen;
  } xc_entry_t;

  // Slot answers a lookup in the given context
  function automatic logic ctx_match(xc_entry_t e, logic [VPN_W-1:0] vpn,
                                     logic [AS_W-1:0] asid, logic [VM_W-1:0] vm,
                                     logic [GEN_W-1:0] gen);
    return e.valid && (e.vpn == vpn) && (e.asid == asid) && (e.vm == vm) && (e.gen == gen);
  endfunction

  // Slot occupies the same page/tag position (generation ignored)
  function automatic logic same_slot(xc_entry_t e, logic [VPN_W-1:0] vpn,
                                     logic [AS_W-1:0] asid, logic [VM_W-1:0] vm);
    return e.valid && (e.vpn == vpn) && (e.asid == asid) && (e.vm == vm);
  endfunction

  // Slot meets the criteria of an invalidation command
  function automatic logic inv_match(xc_entry_t e, inv_op_e op,
                                     logic [VPN_W-1:0] vpn, logic [AS_W-1:0] asid);
    case (op)
      INV_ALL:   return e.valid;
      INV_PAGE:  return e.valid && (e.vpn == vpn);
      INV_SPACE: return e.valid && (e.asid == asid);
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xc_lookup.sv
module xc_lookup
  import xc_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  xc_entry_t        tbl [ENTRIES],
  input  logic [VPN_W-1:0] vpn,
  input  logic [AS_W-1:0]  asid,
  input  logic [VM_W-1:0]  vm,
  input  logic [GEN_W-1:0] gen,
  output logic [ENTRIES-1:0] match_vec,
  output logic             hit,
  output logic [PFN_W-1:0] pfn,
  output logic             writable
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = ctx_match(tbl[i], vpn, asid, vm, gen);
  end

  assign hit = |match_vec;

  always_comb begin
    pfn      = '0;
    writable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        pfn      = pfn | tbl[i].pfn;
        writable = writable | tbl[i].writable;
      end
    end
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               install,
  input  logic [ENTRIES-1:0] reuse_vec,
  input  logic [ENTRIES-1:0] live_vec,
  output logic [IDX_W-1:0]   slot,
  output logic               evict
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] reuse_idx, free_idx;
  logic             reuse_any, free_any;

  always_comb begin
    reuse_idx = '0;
    reuse_any = 1'b0;
    free_idx  = '0;
    free_any  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (reuse_vec[i]) begin
        reuse_idx = IDX_W'(i);
        reuse_any = 1'b1;
      end
      if (!live_vec[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  assign evict = install && !reuse_any && !free_any;
  assign slot  = reuse_any ? reuse_idx : (free_any ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (evict) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AS_W-1:0]  ctx_asid,
  input  logic [VM_W-1:0]  ctx_vm,
  input  logic [GEN_W-1:0] ctx_gen,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_writable,
  input  logic             inv_valid,
  input  logic [1:0]       inv_op,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [AS_W-1:0]  inv_asid
);
  xc_entry_t tbl [ENTRIES];
  xc_entry_t fill_ent;
  inv_op_e   op;

  logic [ENTRIES-1:0] valid_vec, kill_vec, live_vec, reuse_vec, match_vec;
  logic               lk_hit_c, lk_fault_c, sel_writable;
  logic [PFN_W-1:0]   sel_pfn;
  logic               fill_drop, fill_install, evict;
  logic [IDX_W-1:0]   fill_slot;

  assign op = inv_op_e'(inv_op);

  assign fill_ent = '{valid: 1'b1, writable: fill_writable, vpn: fill_vpn, pfn: fill_pfn,
                      asid: ctx_asid, vm: ctx_vm, gen: ctx_gen};

  // Invalidation is resolved before the fill in the same cycle
  assign fill_drop    = fill_valid && inv_valid && inv_match(fill_ent, op, inv_vpn, inv_asid);
  assign fill_install = fill_valid && !fill_drop;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign valid_vec[i] = tbl[i].valid;
    assign kill_vec[i]  = inv_valid && inv_match(tbl[i], op, inv_vpn, inv_asid);
    assign live_vec[i]  = tbl[i].valid && !kill_vec[i];
    assign reuse_vec[i] = live_vec[i] && same_slot(tbl[i], fill_vpn, ctx_asid, ctx_vm);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[i] <= '0;
      end else if (fill_install && (fill_slot == IDX_W'(i))) begin
        tbl[i] <= fill_ent;
      end else if (kill_vec[i]) begin
        tbl[i].valid <= 1'b0;
      end
    end
  end

  xc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .install   (fill_install),
    .reuse_vec (reuse_vec),
    .live_vec  (live_vec),
    .slot      (fill_slot),
    .evict     (evict)
  );

  xc_lookup #(.ENTRIES(ENTRIES)) u_lookup (
    .tbl       (tbl),
    .vpn       (lk_vaddr[VA_W-1:OFF_W]),
    .asid      (ctx_asid),
    .vm        (ctx_vm),
    .gen       (ctx_gen),
    .match_vec (match_vec),
    .hit       (lk_hit_c),
    .pfn       (sel_pfn),
    .writable  (sel_writable)
  );

  assign lk_fault_c = lk_hit_c && lk_write && !sel_writable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit_c && !lk_fault_c;
      rsp_fault <= lk_valid && lk_fault_c;
      rsp_paddr <= (lk_valid && lk_hit_c && !lk_fault_c) ? {sel_pfn, lk_vaddr[OFF_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk
  import xc_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_write,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               inv_valid,
  input logic [1:0]         inv_op,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec,
  input logic               evict
);
  assert_resp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || rsp_hit || rsp_fault) |-> $past(lk_valid));

  assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_paddr == '0));

  assert_flush_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_op == 2'd1) |=> (valid_vec == '0));

  assert_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (!rsp_hit && $past(lk_write)));

  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_evict_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (valid_vec == {ENTRIES{1'b1}}));
endmodule

bind xlate_cache xlate_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_write  (lk_write),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_paddr (rsp_paddr),
  .inv_valid (inv_valid),
  .inv_op    (inv_op),
  .valid_vec (valid_vec),
  .match_vec (match_vec),
  .evict     (evict)
);

// File: tb/xlate_cache_test.sv
`timescale 1ns/1ps
module xlate_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctx_asid = '0;
  logic [3:0]  ctx_vm = 4'd1;
  logic [3:0]  ctx_gen = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_writable = 1'b0;
  logic        inv_valid = 1'b0;
  logic [1:0]  inv_op = '0;
  logic [19:0] inv_vpn = '0;
  logic [7:0]  inv_asid = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [11:0] OFS = 12'hABC;

  always #10 clk = ~clk;

  xlate_cache uut (.*);

  typedef struct packed {
    logic        is_fill;
    logic [19:0] vpn;
    logic [19:0] pfn;
    logic        wr;
    logic [7:0]  asid;
    logic        exp_hit;
    logic        exp_fault;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 20'h00010, 20'h0A010, 1'b1, 8'd3, 1'b0, 1'b0, 4'd8},
    '{1'b1, 20'h00011, 20'h0A011, 1'b0, 8'd3, 1'b0, 1'b0, 4'd8},
    '{1'b1, 20'h00010, 20'h0B010, 1'b1, 8'd4, 1'b0, 1'b0, 4'd8},
    '{1'b0, 20'h00010, 20'h0A010, 1'b0, 8'd3, 1'b1, 1'b0, 4'd1}, // R1
    '{1'b0, 20'h00010, 20'h0B010, 1'b1, 8'd4, 1'b1, 1'b0, 4'd2}, // R2
    '{1'b0, 20'h00011, 20'h0A011, 1'b0, 8'd3, 1'b1, 1'b0, 4'd2},
    '{1'b0, 20'h00011, 20'h00000, 1'b1, 8'd3, 1'b0, 1'b1, 4'd7}, // R7
    '{1'b0, 20'h00011, 20'h00000, 1'b0, 8'd4, 1'b0, 1'b0, 4'd1},
    '{1'b0, 20'h00012, 20'h00000, 1'b0, 8'd3, 1'b0, 1'b0, 4'd1},
    '{1'b0, 20'h00010, 20'h0A010, 1'b0, 8'd3, 1'b1, 1'b0, 4'd2},
    '{1'b1, 20'h00012, 20'h0C012, 1'b1, 8'd3, 1'b0, 1'b0, 4'd8},
    '{1'b0, 20'h00012, 20'h0C012, 1'b1, 8'd3, 1'b1, 1'b0, 4'd8}  // R8
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic wr);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_writable = wr;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv(input logic [1:0] op, input logic [19:0] vpn, input logic [7:0] asid);
    @(negedge clk);
    inv_valid = 1'b1; inv_op = op; inv_vpn = vpn; inv_asid = asid;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic do_both(input logic [19:0] fvpn, input logic [1:0] op,
                         input logic [19:0] ivpn, input logic [7:0] iasid);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = fvpn; fill_pfn = {8'hD0, fvpn[11:0]}; fill_writable = 1'b1;
    inv_valid = 1'b1; inv_op = op; inv_vpn = ivpn; inv_asid = iasid;
    @(negedge clk);
    fill_valid = 1'b0; inv_valid = 1'b0;
  endtask

  // Lookup and compare against a computed expectation
  task automatic look(input logic [19:0] vpn, input logic wr, input bit eh, input bit ef,
                      input logic [19:0] epfn, input string req);
    logic [31:0] exp_pa;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, OFS}; lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0;
    exp_pa = eh ? {epfn, OFS} : 32'h0;
    chk(rsp_valid == 1'b1, req, "rsp_valid", {31'b0, rsp_valid}, 32'h1);
    chk(rsp_hit == eh, req, "rsp_hit", {31'b0, rsp_hit}, {31'b0, eh});
    chk(rsp_fault == ef, req, "rsp_fault", {31'b0, rsp_fault}, {31'b0, ef});
    chk(rsp_paddr == exp_pa, req, "rsp_paddr", rsp_paddr, exp_pa);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({rsp_valid, rsp_hit, rsp_fault} == 3'b0, "R11", "flags in reset",
        {29'b0, rsp_valid, rsp_hit, rsp_fault}, 32'h0);
    chk(rsp_paddr == 32'h0, "R11", "paddr in reset", rsp_paddr, 32'h0);
    rst_n = 1'b1;
    look(20'h00010, 1'b0, 1'b0, 1'b0, 20'h0, "R11");

    // Vector table walk
    for (int i = 0; i < 12; i++) begin
      ctx_asid = VECS[i].asid;
      if (VECS[i].is_fill)
        do_fill(VECS[i].vpn, VECS[i].pfn, VECS[i].wr);
      else
        look(VECS[i].vpn, VECS[i].wr, VECS[i].exp_hit, VECS[i].exp_fault,
             VECS[i].pfn, $sformatf("R%0d", VECS[i].req));
    end

    // R7: read of read-only slot still hits
    ctx_asid = 8'd3;
    look(20'h00011, 1'b0, 1'b1, 1'b0, 20'h0A011, "R7");

    // R1: VM tag mismatch misses
    ctx_vm = 4'd2;
    look(20'h00010, 1'b0, 1'b0, 1'b0, 20'h0, "R1");
    ctx_vm = 4'd1;

    // R5: op 0 does nothing, then flush space 3 keeps space 4
    do_inv(2'd0, 20'h00010, 8'd3);
    look(20'h00010, 1'b0, 1'b1, 1'b0, 20'h0A010, "R5");
    do_inv(2'd3, 20'h0, 8'd3);
    look(20'h00010, 1'b0, 1'b0, 1'b0, 20'h0, "R5");
    ctx_asid = 8'd4;
    look(20'h00010, 1'b0, 1'b1, 1'b0, 20'h0B010, "R5");

    // R4: page flush covers all tags, spares other pages
    ctx_asid = 8'd1; do_fill(20'h00040, 20'h01040, 1'b1); do_fill(20'h00041, 20'h01041, 1'b1);
    ctx_asid = 8'd2; do_fill(20'h00040, 20'h02040, 1'b1);
    do_inv(2'd2, 20'h00040, 8'd0);
    look(20'h00040, 1'b0, 1'b0, 1'b0, 20'h0, "R4");
    ctx_asid = 8'd1;
    look(20'h00040, 1'b0, 1'b0, 1'b0, 20'h0, "R4");
    look(20'h00041, 1'b0, 1'b1, 1'b0, 20'h01041, "R4");

    // R6: generation mismatch; R8 refill overwrites old generation
    ctx_asid = 8'd5; ctx_gen = 4'd1;
    do_fill(20'h00050, 20'h05050, 1'b1);
    look(20'h00050, 1'b0, 1'b1, 1'b0, 20'h05050, "R6");
    ctx_gen = 4'd2;
    look(20'h00050, 1'b0, 1'b0, 1'b0, 20'h0, "R6");
    do_fill(20'h00050, 20'h06050, 1'b1);
    look(20'h00050, 1'b0, 1'b1, 1'b0, 20'h06050, "R8");
    ctx_gen = 4'd1;
    look(20'h00050, 1'b0, 1'b0, 1'b0, 20'h0, "R8");

    // R3: global flush
    ctx_gen = 4'd0; ctx_asid = 8'd1;
    do_inv(2'd1, 20'h0, 8'd0);
    look(20'h00041, 1'b0, 1'b0, 1'b0, 20'h0, "R3");
    ctx_asid = 8'd4;
    look(20'h00010, 1'b0, 1'b0, 1'b0, 20'h0, "R3");

    // R9: fill all 16, then two more evict slots 0 and 1
    ctx_asid = 8'd7;
    for (int k = 0; k < 16; k++) do_fill(20'h00100 + 20'(k), 20'h07100 + 20'(k), 1'b1);
    do_fill(20'h00200, 20'h07200, 1'b1);
    do_fill(20'h00201, 20'h07201, 1'b1);
    look(20'h00100, 1'b0, 1'b0, 1'b0, 20'h0, "R9");
    look(20'h00101, 1'b0, 1'b0, 1'b0, 20'h0, "R9");
    look(20'h00102, 1'b0, 1'b1, 1'b0, 20'h07102, "R9");
    look(20'h00201, 1'b0, 1'b1, 1'b0, 20'h07201, "R9");
    // R9: a hole is used before the pointer (pointer now at slot 2)
    do_inv(2'd2, 20'h00105, 8'd0);
    do_fill(20'h00300, 20'h07300, 1'b1);
    look(20'h00102, 1'b0, 1'b1, 1'b0, 20'h07102, "R9");
    look(20'h00300, 1'b0, 1'b1, 1'b0, 20'h07300, "R9");

    // R10: same-cycle fill and invalidate
    do_inv(2'd1, 20'h0, 8'd0);
    ctx_asid = 8'd9;
    do_both(20'h00400, 2'd3, 20'h0, 8'd9);
    look(20'h00400, 1'b0, 1'b0, 1'b0, 20'h0, "R10");
    do_both(20'h00401, 2'd2, 20'h00999, 8'd0);
    look(20'h00401, 1'b0, 1'b1, 1'b0, 20'hD0401, "R10");
    do_both(20'h00402, 2'd2, 20'h00401, 8'd0);
    look(20'h00401, 1'b0, 1'b0, 1'b0, 20'h0, "R10");
    look(20'h00402, 1'b0, 1'b1, 1'b0, 20'hD0402, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule